// File: doc/BRIEF.md
# Far Pointer Load Sequencer

This block carries out the family of instructions that load a full far pointer from memory into a pair of registers. One pair member is a segment register and the other is a general register. The front end gives it the opcode, the mode and reg fields of the ModRM byte, the operand size, the processor mode and an effective address it has already computed. The block works out which segment register is the target. It then fetches the pointer from memory as two separate reads: the offset comes first and the 16-bit selector second. Finally it writes both registers in the same cycle.

The block makes every check that can reject the instruction before it issues any read. These checks are an unknown opcode, the register (non-memory) operand form and, in real-address mode, an operand that runs past the 64 KiB limit. In protected mode the selector and the target segment are handed to a separate segment-load checker. The block waits for that checker's verdict before it commits anything. Every fault ends the instruction without a register write and reports a vector number.

Top module: `far_ptr_loader`

## Requirements
- R1: Opcode decode picks the segment index (ES=0, SS=2, DS=3, FS=4, GS=5). Without the two-byte escape (two_byte_i=0), C4h gives ES and C5h gives DS. With the escape, B2h gives SS, B4h gives FS and B5h gives GS. The index appears on seg_idx_o and chk_seg_o.
- R2: With 16-bit operand size (op32_i=0) the block reads 2 bytes at the effective address and then 2 bytes at address+2. The general register receives the first value zero-extended, with gpr_wide_o=0.
- R3: With 32-bit operand size (op32_i=1) the block reads 4 bytes at the effective address and then 2 bytes at address+4. The general register receives all 32 bits, with gpr_wide_o=1.
- R4: ModRM mod = 3 (register form) ends the instruction with fault_o=1 and vector 6. No memory read is issued.
- R5: An opcode outside the five in R1, with either escape value, ends the instruction with vector 6 and no memory read.
- R6: In real mode, an operand whose last byte (address + 3, or address + 5 for 32-bit) lies above FFFFh raises vector 13 with no memory read. The faults of R4 and R5 take priority over this one.
- R7: When an instruction faults, gpr_we_o and seg_we_o stay low. On success both go high together in the single cycle in which done_o is high.
- R8: In protected mode the selector and segment index are sent to the checker with a one-cycle chk_req_o pulse. Completion waits for chk_done_i. If chk_fault_i is set with chk_done_i, the block reports chk_vec_i as the vector and writes nothing.
- R9: In real mode the checker is never requested, and the selector is written to the segment register directly.
- R10: A memory request holds its address and size stable until mem_req_ready_i is seen. Each read waits for its response, and the selector read is always issued after the offset read.
- R11: gpr_idx_o carries the ModRM reg field sampled at the start of the instruction.
- R12: After reset the block is idle, with busy_o, done_o, mem_req_valid_o and chk_req_o all low. start_i is ignored while busy_o is high. Inputs are sampled only in the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an instruction (taken only when idle) |
| two_byte_i | input | 1 | Opcode was preceded by the two-byte escape |
| opcode_i | input | 8 | Opcode byte |
| modrm_mod_i | input | 2 | ModRM mod field |
| modrm_reg_i | input | 3 | ModRM reg field, destination general register |
| op32_i | input | 1 | 32-bit operand size |
| real_mode_i | input | 1 | Real-address mode |
| ea_i | input | 32 | Effective address of the pointer |
| busy_o | output | 1 | Instruction in progress |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | 32 | Read address |
| mem_req_bytes_o | output | 3 | Read size in bytes (2 or 4) |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data, little-endian, low bytes first |
| chk_req_o | output | 1 | Segment-load check request pulse |
| chk_sel_o | output | 16 | Selector to check |
| chk_seg_o | output | 3 | Target segment index |
| chk_done_i | input | 1 | Checker result valid |
| chk_fault_i | input | 1 | Checker rejected the selector |
| chk_vec_i | input | 8 | Checker fault vector |
| gpr_we_o | output | 1 | General register write |
| gpr_idx_o | output | 3 | General register index |
| gpr_wide_o | output | 1 | Write is 32 bits wide |
| gpr_data_o | output | 32 | Offset value |
| seg_we_o | output | 1 | Segment register write |
| seg_idx_o | output | 3 | Segment register index |
| seg_sel_o | output | 16 | Selector value |
| done_o | output | 1 | Instruction finished (one cycle) |
| fault_o | output | 1 | Instruction ended in a fault |
| fault_vec_o | output | 8 | Fault vector when fault_o is high |

## Verification
Some properties are checked by assertions on every cycle. Both register writes must always fire together with a clean completion, and a fault must never carry a write. A stalled request must keep its address and size. The second read must sit right after the first and be two bytes wide. In real mode no checker request may appear, a register-form operand must never reach memory, and the written width and index must match the values sampled at start. Other behaviour needs the bench's scenarios: the decode of each opcode, the exact data assembled from memory, the range limit on both sides of FFFFh, the fault-vector priority, checker rejection, and a start pulse ignored while busy.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

    typedef enum logic [2:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OFF_REQ,
        ST_OFF_WAIT,
        ST_SEL_REQ,
        ST_SEL_WAIT,
        ST_CHK_REQ,
        ST_CHK_WAIT,
        ST_COMMIT,
        ST_FAULT
    } st_e;

    typedef struct packed {
        logic       two_byte;
        logic [7:0] opc;
        seg_e       seg;
    } op_map_t;

    localparam int N_OPS = 5;

    localparam op_map_t OP_TABLE [N_OPS] = '{
        '{two_byte: 1'b0, opc: 8'hC4, seg: SEG_ES},
        '{two_byte: 1'b0, opc: 8'hC5, seg: SEG_DS},
        '{two_byte: 1'b1, opc: 8'hB2, seg: SEG_SS},
        '{two_byte: 1'b1, opc: 8'hB4, seg: SEG_FS},
        '{two_byte: 1'b1, opc: 8'hB5, seg: SEG_GS}
    };

    localparam logic [2:0] SEL_BYTES = 3'd2;

    typedef struct packed {
        seg_e       seg;
        logic [2:0] gidx;
        logic       wide;
        logic       rmode;
    } ctx_t;

    // size of the leading (offset) part of the pointer
    function automatic logic [2:0] lead_bytes(input logic wide);
        return wide ? 3'd4 : 3'd2;
    endfunction

    // distance from the first to the last byte of the whole pointer
    function automatic logic [2:0] last_byte_off(input logic wide);
        return wide ? 3'd5 : 3'd3;
    endfunction

endpackage

// File: rtl/fpl_opdecode.sv
module fpl_opdecode
    import fpl_pkg::*;
(
    input  logic       two_byte_i,
    input  logic [7:0] opcode_i,
    input  logic [1:0] mod_i,
    output seg_e       seg_o,
    output logic       ud_o
);

    logic [N_OPS-1:0] hit;
    logic             known;

    for (genvar k = 0; k < N_OPS; k++) begin : g_match
        assign hit[k] = (OP_TABLE[k].two_byte == two_byte_i) &&
                        (OP_TABLE[k].opc == opcode_i);
    end

    always_comb begin
        seg_o = SEG_DS;
        for (int k = 0; k < N_OPS; k++) begin
            if (hit[k]) begin
                seg_o = OP_TABLE[k].seg;
            end
        end
    end

    assign known = |hit;
    // unknown opcode or register-form operand both mean invalid opcode
    assign ud_o  = !known || (mod_i == 2'b11);

endmodule

// File: rtl/fpl_span.sv
module fpl_span
    import fpl_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ea_i,
    input  logic          wide_i,
    input  logic          rmode_i,
    output logic [AW-1:0] sel_addr_o,
    output logic          span_flt_o
);

    localparam logic [AW:0] RLIM = {{(AW-16){1'b0}}, 17'h0FFFF};

    logic [AW:0] last_byte;

    assign last_byte  = {1'b0, ea_i} + {{(AW-2){1'b0}}, last_byte_off(wide_i)};
    assign span_flt_o = rmode_i && (last_byte > RLIM);
    assign sel_addr_o = ea_i + {{(AW-3){1'b0}}, lead_bytes(wide_i)};

endmodule

// File: rtl/fpl_sequencer.sv
module fpl_sequencer
    import fpl_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int SW     = 16,
    parameter int VW     = 8,
    parameter int UD_VEC = 6,
    parameter int GP_VEC = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          ud_i,
    input  logic          span_flt_i,
    input  ctx_t          ctx_i,
    input  logic [AW-1:0] off_addr_i,
    input  logic [AW-1:0] sel_addr_i,
    output logic          busy_o,
    output logic          mem_req_valid_o,
    input  logic          mem_req_ready_i,
    output logic [AW-1:0] mem_req_addr_o,
    output logic [2:0]    mem_req_bytes_o,
    input  logic          mem_rsp_valid_i,
    input  logic [DW-1:0] mem_rsp_data_i,
    output logic          chk_req_o,
    output logic [SW-1:0] chk_sel_o,
    output logic [2:0]    chk_seg_o,
    input  logic          chk_done_i,
    input  logic          chk_fault_i,
    input  logic [VW-1:0] chk_vec_i,
    output logic          gpr_we_o,
    output logic [2:0]    gpr_idx_o,
    output logic          gpr_wide_o,
    output logic [DW-1:0] gpr_data_o,
    output logic          seg_we_o,
    output logic [2:0]    seg_idx_o,
    output logic [SW-1:0] seg_sel_o,
    output logic          done_o,
    output logic          fault_o,
    output logic [VW-1:0] fault_vec_o
);

    st_e           state;
    ctx_t          ctx_q;
    logic [AW-1:0] off_addr_q;
    logic [AW-1:0] sel_addr_q;
    logic [DW-1:0] off_q;
    logic [SW-1:0] sel_q;
    logic [VW-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ctx_q      <= '0;
            off_addr_q <= '0;
            sel_addr_q <= '0;
            off_q      <= '0;
            sel_q      <= '0;
            vec_q      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        ctx_q      <= ctx_i;
                        off_addr_q <= off_addr_i;
                        sel_addr_q <= sel_addr_i;
                        if (ud_i) begin
                            vec_q <= VW'(UD_VEC);
                            state <= ST_FAULT;
                        end else if (span_flt_i) begin
                            vec_q <= VW'(GP_VEC);
                            state <= ST_FAULT;
                        end else begin
                            state <= ST_OFF_REQ;
                        end
                    end
                end
                ST_OFF_REQ: begin
                    if (mem_req_ready_i) state <= ST_OFF_WAIT;
                end
                ST_OFF_WAIT: begin
                    if (mem_rsp_valid_i) begin
                        off_q <= ctx_q.wide ? mem_rsp_data_i
                                            : {{(DW-16){1'b0}}, mem_rsp_data_i[15:0]};
                        state <= ST_SEL_REQ;
                    end
                end
                ST_SEL_REQ: begin
                    if (mem_req_ready_i) state <= ST_SEL_WAIT;
                end
                ST_SEL_WAIT: begin
                    if (mem_rsp_valid_i) begin
                        sel_q <= mem_rsp_data_i[SW-1:0];
                        state <= ctx_q.rmode ? ST_COMMIT : ST_CHK_REQ;
                    end
                end
                ST_CHK_REQ: begin
                    state <= ST_CHK_WAIT;
                end
                ST_CHK_WAIT: begin
                    if (chk_done_i) begin
                        if (chk_fault_i) begin
                            vec_q <= chk_vec_i;
                            state <= ST_FAULT;
                        end else begin
                            state <= ST_COMMIT;
                        end
                    end
                end
                ST_COMMIT: state <= ST_IDLE;
                ST_FAULT:  state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o          = (state != ST_IDLE);
    assign mem_req_valid_o = (state == ST_OFF_REQ) || (state == ST_SEL_REQ);
    assign mem_req_addr_o  = (state == ST_SEL_REQ) ? sel_addr_q : off_addr_q;
    assign mem_req_bytes_o = (state == ST_SEL_REQ) ? SEL_BYTES : lead_bytes(ctx_q.wide);

    assign chk_req_o  = (state == ST_CHK_REQ);
    assign chk_sel_o  = sel_q;
    assign chk_seg_o  = ctx_q.seg;

    assign gpr_we_o   = (state == ST_COMMIT);
    assign gpr_idx_o  = ctx_q.gidx;
    assign gpr_wide_o = ctx_q.wide;
    assign gpr_data_o = off_q;
    assign seg_we_o   = (state == ST_COMMIT);
    assign seg_idx_o  = ctx_q.seg;
    assign seg_sel_o  = sel_q;

    assign done_o      = (state == ST_COMMIT) || (state == ST_FAULT);
    assign fault_o     = (state == ST_FAULT);
    assign fault_vec_o = (state == ST_FAULT) ? vec_q : '0;

endmodule

// File: rtl/far_ptr_loader.sv
module far_ptr_loader
    import fpl_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int SW     = 16,
    parameter int VW     = 8,
    parameter int UD_VEC = 6,
    parameter int GP_VEC = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          two_byte_i,
    input  logic [7:0]    opcode_i,
    input  logic [1:0]    modrm_mod_i,
    input  logic [2:0]    modrm_reg_i,
    input  logic          op32_i,
    input  logic          real_mode_i,
    input  logic [AW-1:0] ea_i,
    output logic          busy_o,
    output logic          mem_req_valid_o,
    input  logic          mem_req_ready_i,
    output logic [AW-1:0] mem_req_addr_o,
    output logic [2:0]    mem_req_bytes_o,
    input  logic          mem_rsp_valid_i,
    input  logic [DW-1:0] mem_rsp_data_i,
    output logic          chk_req_o,
    output logic [SW-1:0] chk_sel_o,
    output logic [2:0]    chk_seg_o,
    input  logic          chk_done_i,
    input  logic          chk_fault_i,
    input  logic [VW-1:0] chk_vec_i,
    output logic          gpr_we_o,
    output logic [2:0]    gpr_idx_o,
    output logic          gpr_wide_o,
    output logic [DW-1:0] gpr_data_o,
    output logic          seg_we_o,
    output logic [2:0]    seg_idx_o,
    output logic [SW-1:0] seg_sel_o,
    output logic          done_o,
    output logic          fault_o,
    output logic [VW-1:0] fault_vec_o
);

    seg_e          dec_seg;
    logic          dec_ud;
    logic          span_flt;
    logic [AW-1:0] sel_addr;
    ctx_t          ctx;

    fpl_opdecode u_dec (
        .two_byte_i (two_byte_i),
        .opcode_i   (opcode_i),
        .mod_i      (modrm_mod_i),
        .seg_o      (dec_seg),
        .ud_o       (dec_ud)
    );

    fpl_span #(.AW(AW)) u_span (
        .ea_i       (ea_i),
        .wide_i     (op32_i),
        .rmode_i    (real_mode_i),
        .sel_addr_o (sel_addr),
        .span_flt_o (span_flt)
    );

    always_comb begin
        ctx.seg   = dec_seg;
        ctx.gidx  = modrm_reg_i;
        ctx.wide  = op32_i;
        ctx.rmode = real_mode_i;
    end

    fpl_sequencer #(
        .AW(AW), .DW(DW), .SW(SW), .VW(VW), .UD_VEC(UD_VEC), .GP_VEC(GP_VEC)
    ) u_seq (
        .clk             (clk),
        .rst             (rst),
        .start_i         (start_i),
        .ud_i            (dec_ud),
        .span_flt_i      (span_flt),
        .ctx_i           (ctx),
        .off_addr_i      (ea_i),
        .sel_addr_i      (sel_addr),
        .busy_o          (busy_o),
        .mem_req_valid_o (mem_req_valid_o),
        .mem_req_ready_i (mem_req_ready_i),
        .mem_req_addr_o  (mem_req_addr_o),
        .mem_req_bytes_o (mem_req_bytes_o),
        .mem_rsp_valid_i (mem_rsp_valid_i),
        .mem_rsp_data_i  (mem_rsp_data_i),
        .chk_req_o       (chk_req_o),
        .chk_sel_o       (chk_sel_o),
        .chk_seg_o       (chk_seg_o),
        .chk_done_i      (chk_done_i),
        .chk_fault_i     (chk_fault_i),
        .chk_vec_i       (chk_vec_i),
        .gpr_we_o        (gpr_we_o),
        .gpr_idx_o       (gpr_idx_o),
        .gpr_wide_o      (gpr_wide_o),
        .gpr_data_o      (gpr_data_o),
        .seg_we_o        (seg_we_o),
        .seg_idx_o       (seg_idx_o),
        .seg_sel_o       (seg_sel_o),
        .done_o          (done_o),
        .fault_o         (fault_o),
        .fault_vec_o     (fault_vec_o)
    );

endmodule

// File: rtl/fpl_props.sv
module fpl_props #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          busy_o,
    input logic [1:0]    modrm_mod_i,
    input logic [2:0]    modrm_reg_i,
    input logic          op32_i,
    input logic          real_mode_i,
    input logic          mem_req_valid_o,
    input logic          mem_req_ready_i,
    input logic [AW-1:0] mem_req_addr_o,
    input logic [2:0]    mem_req_bytes_o,
    input logic          chk_req_o,
    input logic          gpr_we_o,
    input logic [2:0]    gpr_idx_o,
    input logic          gpr_wide_o,
    input logic          seg_we_o,
    input logic          done_o,
    input logic          fault_o
);

    logic          rmode_q;
    logic          wide_q;
    logic          regform_q;
    logic [2:0]    gidx_q;
    logic [1:0]    acc_n;
    logic [AW-1:0] first_addr;
    logic [2:0]    first_bytes;

    always_ff @(posedge clk) begin
        if (rst) begin
            rmode_q     <= 1'b0;
            wide_q      <= 1'b0;
            regform_q   <= 1'b0;
            gidx_q      <= '0;
            acc_n       <= '0;
            first_addr  <= '0;
            first_bytes <= '0;
        end else if (start_i && !busy_o) begin
            rmode_q   <= real_mode_i;
            wide_q    <= op32_i;
            regform_q <= (modrm_mod_i == 2'b11);
            gidx_q    <= modrm_reg_i;
            acc_n     <= '0;
        end else if (mem_req_valid_o && mem_req_ready_i) begin
            if (acc_n == 2'd0) begin
                first_addr  <= mem_req_addr_o;
                first_bytes <= mem_req_bytes_o;
            end
            if (acc_n != 2'd3) acc_n <= acc_n + 2'd1;
        end
    end

    assert_commit_pair_R7: assert property (@(posedge clk) disable iff (rst)
        gpr_we_o |-> (seg_we_o && done_o && !fault_o));

    assert_fault_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (!gpr_we_o && !seg_we_o && done_o));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && !mem_req_ready_i) |=>
            (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_bytes_o)));

    assert_sel_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && acc_n == 2'd1) |->
            (mem_req_addr_o == first_addr + {{(AW-3){1'b0}}, first_bytes} &&
             mem_req_bytes_o == 3'd2));

    assert_lead_size_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && acc_n == 2'd0) |->
            (mem_req_bytes_o == (wide_q ? 3'd4 : 3'd2)));

    assert_no_regform_read_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o |-> !regform_q);

    assert_real_nochk_R9: assert property (@(posedge clk) disable iff (rst)
        chk_req_o |-> !rmode_q);

    assert_dest_fields_R11: assert property (@(posedge clk) disable iff (rst)
        gpr_we_o |-> (gpr_idx_o == gidx_q && gpr_wide_o == wide_q));

endmodule

bind far_ptr_loader fpl_props #(.AW(AW)) u_props (
    .clk             (clk),
    .rst             (rst),
    .start_i         (start_i),
    .busy_o          (busy_o),
    .modrm_mod_i     (modrm_mod_i),
    .modrm_reg_i     (modrm_reg_i),
    .op32_i          (op32_i),
    .real_mode_i     (real_mode_i),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_bytes_o (mem_req_bytes_o),
    .chk_req_o       (chk_req_o),
    .gpr_we_o        (gpr_we_o),
    .gpr_idx_o       (gpr_idx_o),
    .gpr_wide_o      (gpr_wide_o),
    .seg_we_o        (seg_we_o),
    .done_o          (done_o),
    .fault_o         (fault_o)
);

// File: tb/far_ptr_loader_tb_top.sv
`timescale 1ns/1ps
module far_ptr_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        two_byte_i = 1'b0;
    logic [7:0]  opcode_i = 8'h00;
    logic [1:0]  modrm_mod_i = 2'b00;
    logic [2:0]  modrm_reg_i = 3'd0;
    logic        op32_i = 1'b0;
    logic        real_mode_i = 1'b0;
    logic [31:0] ea_i = 32'h0;
    logic        busy_o;
    logic        mem_req_valid_o;
    logic        mem_req_ready_i = 1'b0;
    logic [31:0] mem_req_addr_o;
    logic [2:0]  mem_req_bytes_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_data_i = 32'h0;
    logic        chk_req_o;
    logic [15:0] chk_sel_o;
    logic [2:0]  chk_seg_o;
    logic        chk_done_i = 1'b0;
    logic        chk_fault_i = 1'b0;
    logic [7:0]  chk_vec_i = 8'h0;
    logic        gpr_we_o;
    logic [2:0]  gpr_idx_o;
    logic        gpr_wide_o;
    logic [31:0] gpr_data_o;
    logic        seg_we_o;
    logic [2:0]  seg_idx_o;
    logic [15:0] seg_sel_o;
    logic        done_o;
    logic        fault_o;
    logic [7:0]  fault_vec_o;

    always #10 clk = ~clk;

    far_ptr_loader dut_i (.*);

    typedef struct {
        bit        fault;
        bit [7:0]  vec;
        bit [2:0]  gidx;
        bit        wide;
        bit [31:0] gdata;
        bit [2:0]  sidx;
        bit [15:0] sel;
        string     tag;
    } exp_t;
    typedef struct { bit [31:0] addr; bit [2:0] bytes; string tag; } rd_t;
    typedef struct { bit [15:0] sel; bit [2:0] seg; string tag; } ck_t;

    exp_t exp_q[$];
    rd_t  rd_q[$];
    ck_t  ck_q[$];

    int  n_checks = 0;
    int  n_errs   = 0;
    bit  reported = 0;
    bit  chk_fail_mode = 0;
    localparam bit [7:0] CHK_VEC = 8'd11;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    endtask

    function automatic bit [7:0] mem_byte(input bit [31:0] a);
        bit [31:0] t;
        t = a * 32'd37 + (a >> 8) * 32'd11 + 32'd5;
        return t[7:0];
    endfunction

    function automatic bit [31:0] mem_word(input bit [31:0] a, input bit [2:0] n);
        bit [31:0] w;
        w = {16'h0, mem_byte(a + 32'd1), mem_byte(a)};
        if (n == 3'd4) w[31:16] = {mem_byte(a + 32'd3), mem_byte(a + 32'd2)};
        return w;
    endfunction

    // memory responder: checks order/addresses, answers one cycle after accept
    initial begin
        bit        pend = 0;
        bit [31:0] pend_data = 0;
        int        cyc = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid_i = 1'b0;
            if (pend) begin
                mem_rsp_valid_i = 1'b1;
                mem_rsp_data_i  = pend_data;
                pend = 0;
            end
            cyc++;
            mem_req_ready_i = (cyc % 3 != 1);
            if (!rst && mem_req_valid_o && mem_req_ready_i) begin
                if (rd_q.size() == 0) begin
                    check(0, "R10", "unexpected read addr", mem_req_addr_o, 0);
                end else begin
                    rd_t r;
                    r = rd_q.pop_front();
                    check(mem_req_addr_o == r.addr, {r.tag, "/R10"}, "read addr",
                          mem_req_addr_o, r.addr);
                    check(mem_req_bytes_o == r.bytes, {r.tag, "/R10"}, "read bytes",
                          mem_req_bytes_o, r.bytes);
                end
                pend = 1;
                pend_data = mem_word(mem_req_addr_o, mem_req_bytes_o);
            end
        end
    end

    // segment-load checker model
    initial begin
        int cdelay = 0;
        forever begin
            @(negedge clk);
            chk_done_i = 1'b0;
            if (cdelay > 0) begin
                cdelay--;
                if (cdelay == 0) begin
                    chk_done_i  = 1'b1;
                    chk_fault_i = chk_fail_mode;
                    chk_vec_i   = CHK_VEC;
                end
            end
            if (!rst && chk_req_o) begin
                if (ck_q.size() == 0) begin
                    check(0, "R9", "unexpected checker request", 1, 0);
                end else begin
                    ck_t c;
                    c = ck_q.pop_front();
                    check(chk_sel_o == c.sel, {c.tag, "/R8"}, "chk selector", chk_sel_o, c.sel);
                    check(chk_seg_o == c.seg, {c.tag, "/R1"}, "chk segment", chk_seg_o, c.seg);
                end
                cdelay = 2;
            end
        end
    end

    // result monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done_o) begin
                if (exp_q.size() == 0) begin
                    check(0, "R12", "unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(fault_o == e.fault, {e.tag, "/R7"}, "fault", fault_o, e.fault);
                    if (e.fault) begin
                        check(fault_vec_o == e.vec, e.tag, "vector", fault_vec_o, e.vec);
                        check(!gpr_we_o && !seg_we_o, {e.tag, "/R7"}, "write on fault",
                              {gpr_we_o, seg_we_o}, 0);
                    end else begin
                        check(gpr_we_o && seg_we_o, {e.tag, "/R7"}, "write pair",
                              {gpr_we_o, seg_we_o}, 3);
                        check(gpr_idx_o == e.gidx, {e.tag, "/R11"}, "gpr idx", gpr_idx_o, e.gidx);
                        check(gpr_wide_o == e.wide, e.tag, "gpr wide", gpr_wide_o, e.wide);
                        check(gpr_data_o == e.gdata, e.tag, "gpr data", gpr_data_o, e.gdata);
                        check(seg_idx_o == e.sidx, {e.tag, "/R1"}, "seg idx", seg_idx_o, e.sidx);
                        check(seg_sel_o == e.sel, e.tag, "selector", seg_sel_o, e.sel);
                    end
                end
            end
        end
    end

    // driver: computes expectations, pushes them, then starts the instruction
    task automatic run_op(input bit tb, input bit [7:0] opc, input bit [1:0] md,
                          input bit [2:0] rg, input bit w, input bit rm,
                          input bit [31:0] ea, input bit cf, input bit poke,
                          input string tag);
        exp_t     e;
        bit       known = 1;
        bit [2:0] sidx  = 3'd0;
        bit       ud;
        bit       gp;
        bit [2:0] lead;
        longint   last;
        if (!tb && opc == 8'hC4)      sidx = 3'd0;
        else if (!tb && opc == 8'hC5) sidx = 3'd3;
        else if (tb && opc == 8'hB2)  sidx = 3'd2;
        else if (tb && opc == 8'hB4)  sidx = 3'd4;
        else if (tb && opc == 8'hB5)  sidx = 3'd5;
        else known = 0;
        lead = w ? 3'd4 : 3'd2;
        last = longint'(ea) + (w ? 5 : 3);
        ud = !known || (md == 2'b11);
        gp = !ud && rm && (last > 64'hFFFF);
        e.tag = tag; e.gidx = rg; e.wide = w; e.sidx = sidx;
        e.fault = 0; e.vec = 0; e.gdata = 0; e.sel = 0;
        if (ud) begin
            e.fault = 1; e.vec = 8'd6;
        end else if (gp) begin
            e.fault = 1; e.vec = 8'd13;
        end else begin
            rd_t r;
            r.addr = ea; r.bytes = lead; r.tag = tag; rd_q.push_back(r);
            r.addr = ea + 32'(lead); r.bytes = 3'd2; rd_q.push_back(r);
            e.gdata = mem_word(ea, lead);
            e.sel   = mem_word(ea + 32'(lead), 3'd2);
            if (!rm) begin
                ck_t c;
                c.sel = e.sel; c.seg = sidx; c.tag = tag; ck_q.push_back(c);
                if (cf) begin
                    e.fault = 1; e.vec = CHK_VEC;
                end
            end
        end
        exp_q.push_back(e);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        chk_fail_mode = cf;
        two_byte_i = tb; opcode_i = opc; modrm_mod_i = md; modrm_reg_i = rg;
        op32_i = w; real_mode_i = rm; ea_i = ea; start_i = 1'b1;
        @(negedge clk);
        // scramble inputs: the block must use only the start-cycle values
        start_i = poke; two_byte_i = 1'b0; opcode_i = 8'hC4; modrm_mod_i = 2'b00;
        modrm_reg_i = ~rg; op32_i = ~w; real_mode_i = ~rm; ea_i = ~ea;
        @(negedge clk);
        start_i = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(rd_q.size() == 0 && ck_q.size() == 0, {tag, "/R10"},
              "outstanding reads/checks", rd_q.size() + ck_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R12", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && !mem_req_valid_o && !chk_req_o, "R12",
              "reset idle", {busy_o, done_o, mem_req_valid_o, chk_req_o}, 0);

        run_op(1'b0, 8'hC5, 2'b00, 3'd3, 1'b0, 1'b0, 32'h0000_1000, 1'b0, 1'b0, "R2 DS16");
        run_op(1'b0, 8'hC4, 2'b10, 3'd7, 1'b1, 1'b0, 32'h1234_2001, 1'b0, 1'b0, "R3 ES32");
        run_op(1'b1, 8'hB2, 2'b01, 3'd1, 1'b0, 1'b1, 32'h0000_0300, 1'b0, 1'b0, "R9 SS16real");
        run_op(1'b1, 8'hB4, 2'b00, 3'd5, 1'b1, 1'b1, 32'h0000_FFFA, 1'b0, 1'b0, "R6 FS32edge");
        run_op(1'b1, 8'hB5, 2'b00, 3'd2, 1'b1, 1'b1, 32'h0000_FFFB, 1'b0, 1'b0, "R6 GS32over");
        run_op(1'b0, 8'hC5, 2'b00, 3'd0, 1'b0, 1'b1, 32'h0000_FFFC, 1'b0, 1'b0, "R6 DS16edge");
        run_op(1'b0, 8'hC5, 2'b00, 3'd0, 1'b0, 1'b1, 32'h0000_FFFD, 1'b0, 1'b0, "R6 DS16over");
        run_op(1'b0, 8'hC4, 2'b00, 3'd4, 1'b0, 1'b1, 32'h0001_0000, 1'b0, 1'b0, "R6 highword");
        run_op(1'b1, 8'hB5, 2'b11, 3'd2, 1'b1, 1'b0, 32'h0000_4000, 1'b0, 1'b0, "R4 regform");
        run_op(1'b0, 8'hC4, 2'b11, 3'd2, 1'b0, 1'b1, 32'h0000_FFFF, 1'b0, 1'b0, "R4 prio");
        run_op(1'b0, 8'hB2, 2'b00, 3'd1, 1'b0, 1'b0, 32'h0000_0100, 1'b0, 1'b0, "R5 noesc");
        run_op(1'b1, 8'hC5, 2'b00, 3'd1, 1'b0, 1'b1, 32'h0000_0100, 1'b0, 1'b0, "R5 esc");
        run_op(1'b1, 8'hB4, 2'b00, 3'd6, 1'b1, 1'b0, 32'h8000_0010, 1'b1, 1'b0, "R8 chkfault");
        run_op(1'b1, 8'hB5, 2'b01, 3'd6, 1'b0, 1'b0, 32'h0000_7FF0, 1'b0, 1'b0, "R1 GS16");
        run_op(1'b1, 8'hB2, 2'b00, 3'd2, 1'b1, 1'b0, 32'hFFFF_FFF8, 1'b0, 1'b1, "R12 poke");
        run_op(1'b0, 8'hC5, 2'b00, 3'd5, 1'b1, 1'b1, 32'h0000_0040, 1'b0, 1'b0, "R11 DS32real");

        check(exp_q.size() == 0, "R12", "pending results", exp_q.size(), 0);
        report();
    end

endmodule